// File: doc/BRIEF.md
# Register Hazard Scoreboard for Multi-Unit Issue

This block controls issue and completion for a processor core that has ten independent functional units. None of the units is pipelined. Each cycle the block may accept one decoded instruction. The instruction carries a unit class, one destination register, two source registers and a tag that identifies it. The block decides whether the instruction can issue and which physical unit receives it. It records which unit will produce each register. It tells each unit when its operands may be read, and it grants each unit permission to write back its result.

The block treats each kind of hazard in its own way. Issue stalls when the needed unit class is fully occupied or when the destination already waits for an unfinished result. A missing operand holds back only the start of the unit that needs it. A result that would overwrite a value an older instruction has not yet read stays parked inside its unit until that read is done. The functional units are modelled inside the block as fixed-latency timers. The "value" a unit writes is its instruction tag, so the register file shows which instruction wrote each register last. The operand tags a unit captured are carried out with its write-back.

Top module: `hazard_scoreboard`

## Requirements
- R1: After reset no unit is busy and no register is reserved. `in_ready` is 1 for any class and destination, `fu_start`, `fu_grant` and `wb_valid` are 0, and every register holds tag 0.
- R2: The class code `in_class` maps to units as follows: 0→unit 0, 1→unit 1, 2→unit 2, 3→unit 3, 4→unit 4, 5→units 5 and 6, 6→unit 7, 7→units 8 and 9. `iss_unit` reports the chosen unit during the accepting cycle.
- R3: `in_ready` is 0 while every unit of the requested class is busy, and the instruction is accepted once a unit of that class is free.
- R4: `in_ready` is 0 while the requested destination is reserved by an issued, unwritten instruction. A different destination is accepted in that state.
- R5: For classes 5 and 7, a busy copy makes the block pick the idle copy. When both copies are idle, the block picks the copy it did not pick last for that class, and the first pick after reset is the lower-numbered unit.
- R6: A unit reads its operands (`fu_start`) only once each source holds the result of the most recent older instruction that writes that source. The operand tags carried out at write-back equal those of in-order execution.
- R7: A finished result whose destination is a source that an older, not-yet-started instruction still has to read is held in its unit until that read has happened.
- R8: From the accepting cycle to the write-back cycle a unit takes LAT+2 cycles, and never fewer than 3. LAT is 1 for classes 0–3 and 7, `LAT_FADD` for class 4, `LAT_FMUL` for class 5 and `LAT_FDIV` for class 6.
- R9: At most one unit writes back per cycle. When several units are eligible, the lowest-numbered unit wins.
- R10: Writes to each register occur in program order. After all instructions complete, every register holds the tag of its last writer in program order.
- R11: A unit becomes free in the cycle after its write-back. It cannot accept a new instruction during the write-back cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_class | input | 3 | Unit class code |
| in_dst | input | log2(NREG) | Destination register |
| in_src1 | input | log2(NREG) | First source register |
| in_src2 | input | log2(NREG) | Second source register |
| in_tag | input | TAG_W | Identifier written as the result |
| in_ready | output | 1 | The offered instruction can be accepted this cycle |
| iss_unit | output | 4 | Unit chosen for the offered instruction |
| fu_start | output | 10 | Per unit: operands are read this cycle |
| fu_grant | output | 10 | Per unit: write-back permitted this cycle |
| wb_valid | output | 1 | A write-back occurs this cycle |
| wb_unit | output | 4 | Unit writing back |
| wb_reg | output | log2(NREG) | Register being written |
| wb_tag | output | TAG_W | Tag being written |
| wb_op1 | output | TAG_W | First operand tag the writing unit read |
| wb_op2 | output | TAG_W | Second operand tag the writing unit read |

## Verification
The checker watches every cycle for several properties. The write grant must never name two units at once. An accepted instruction must never land on a busy unit or on a reserved destination. A unit must never write back without having read its operands first, or sooner than three cycles after acceptance. The scenarios in the bench show the rest. They confirm that the operand tags and the per-register write order match in-order execution, which is what shows that read-before-write and write-after-read ordering hold across chains of dependent instructions. They also cover the alternation between twin units, the exact latencies, the write priority when two results finish together, and the one-cycle delay before a freed unit can be reused.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam int NUM_CLASS = 8;
   localparam int NUM_UNIT  = 10;
   localparam int CLASS_W   = 3;
   localparam int UNIT_W    = 4;

   typedef enum logic [CLASS_W-1:0] {
      CL_BRANCH = 3'd0,
      CL_LOGIC  = 3'd1,
      CL_SHIFT  = 3'd2,
      CL_IADD   = 3'd3,
      CL_FADD   = 3'd4,
      CL_FMUL   = 3'd5,
      CL_FDIV   = 3'd6,
      CL_INCR   = 3'd7
   } fu_class_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_EXEC = 2'd2,
      PH_HOLD = 2'd3
   } unit_phase_e;

   // first physical unit of a class
   function automatic int class_base(input int c);
      case (c)
         5:       return 5;
         6:       return 7;
         7:       return 8;
         default: return c;
      endcase
   endfunction

   // number of physical copies of a class
   function automatic int class_copies(input int c);
      return (c == 5 || c == 7) ? 2 : 1;
   endfunction

   // class served by a physical unit
   function automatic int unit_class(input int u);
      int cls;
      cls = 0;
      for (int c = 0; c < NUM_CLASS; c++)
         if (u >= class_base(c) && u < class_base(c) + class_copies(c))
            cls = c;
      return cls;
   endfunction
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat
   import sb_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int TAG_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [$clog2(NREG)-1:0] set_reg,
   input  logic [UNIT_W-1:0]      set_unit,
   input  logic                   clr_en,
   input  logic [$clog2(NREG)-1:0] clr_reg,
   input  logic [TAG_W-1:0]       clr_tag,
   output logic [NREG-1:0]        pend_v,
   output logic [UNIT_W-1:0]      pend_u   [NREG],
   output logic [TAG_W-1:0]       arch_tag [NREG]
);
   localparam int RW = $clog2(NREG);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_v[r]   <= 1'b0;
            pend_u[r]   <= '0;
            arch_tag[r] <= '0;
         end else begin
            if (clr_en && clr_reg == RW'(r)) begin
               pend_v[r]   <= 1'b0;
               arch_tag[r] <= clr_tag;
            end
            if (set_en && set_reg == RW'(r)) begin
               pend_v[r] <= 1'b1;
               pend_u[r] <= set_unit;
            end
         end
      end
   end
endmodule

// File: rtl/sb_issue.sv
module sb_issue
   import sb_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [CLASS_W-1:0]      in_class,
   input  logic [$clog2(NREG)-1:0] in_dst,
   input  logic [NREG-1:0]         pend_v,
   input  logic [NUM_UNIT-1:0]     unit_busy,
   output logic                    in_ready,
   output logic [UNIT_W-1:0]       pick
);
   logic [NUM_CLASS-1:0] avail;
   logic [UNIT_W-1:0]    pick_c [NUM_CLASS];
   logic                 fire;

   assign fire = in_valid && in_ready;

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      localparam int B = class_base(c);
      if (class_copies(c) == 2) begin : g_dual
         logic last_hi;
         logic both_idle;
         assign both_idle = !unit_busy[B] && !unit_busy[B+1];
         assign avail[c]  = !unit_busy[B] || !unit_busy[B+1];
         assign pick_c[c] = both_idle ? (last_hi ? UNIT_W'(B) : UNIT_W'(B+1))
                                      : (!unit_busy[B] ? UNIT_W'(B) : UNIT_W'(B+1));
         always_ff @(posedge clk) begin
            if (!rst_n)
               last_hi <= 1'b1;
            else if (fire && in_class == CLASS_W'(c))
               last_hi <= (pick_c[c] == UNIT_W'(B+1));
         end
      end else begin : g_single
         assign avail[c]  = !unit_busy[B];
         assign pick_c[c] = UNIT_W'(B);
      end
   end

   assign in_ready = avail[in_class] && !pend_v[in_dst];
   assign pick     = pick_c[in_class];
endmodule

// File: rtl/sb_unit.sv
module sb_unit
   import sb_pkg::*;
#(
   parameter int RW    = 3,
   parameter int TAG_W = 8,
   parameter int LAT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_en,
   input  logic [RW-1:0]     iss_dst,
   input  logic [RW-1:0]     iss_src1,
   input  logic [RW-1:0]     iss_src2,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              iss_rdy1,
   input  logic              iss_rdy2,
   input  logic [UNIT_W-1:0] iss_prod1,
   input  logic [UNIT_W-1:0] iss_prod2,
   input  logic              wb_en,
   input  logic [UNIT_W-1:0] wb_from,
   input  logic [TAG_W-1:0]  opnd1,
   input  logic [TAG_W-1:0]  opnd2,
   input  logic              grant,
   output logic              busy,
   output logic              waiting,
   output logic              start,
   output logic              hold,
   output logic [RW-1:0]     dst,
   output logic [RW-1:0]     src1,
   output logic [RW-1:0]     src2,
   output logic              rdy1,
   output logic              rdy2,
   output logic [TAG_W-1:0]  tag,
   output logic [TAG_W-1:0]  res1,
   output logic [TAG_W-1:0]  res2
);
   localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

   unit_phase_e       ph;
   logic [CNT_W-1:0]  cnt;
   logic [UNIT_W-1:0] prod1, prod2;

   assign busy    = (ph != PH_IDLE);
   assign waiting = (ph == PH_WAIT);
   assign start   = waiting && rdy1 && rdy2;
   assign hold    = (ph == PH_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         dst   <= '0;
         src1  <= '0;
         src2  <= '0;
         rdy1  <= 1'b0;
         rdy2  <= 1'b0;
         prod1 <= '0;
         prod2 <= '0;
         tag   <= '0;
         res1  <= '0;
         res2  <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (iss_en) begin
               ph    <= PH_WAIT;
               dst   <= iss_dst;
               src1  <= iss_src1;
               src2  <= iss_src2;
               tag   <= iss_tag;
               rdy1  <= iss_rdy1;
               rdy2  <= iss_rdy2;
               prod1 <= iss_prod1;
               prod2 <= iss_prod2;
            end
            PH_WAIT: begin
               if (start) begin
                  ph   <= PH_EXEC;
                  cnt  <= CNT_W'(LAT-1);
                  res1 <= opnd1;
                  res2 <= opnd2;
               end
               if (wb_en && !rdy1 && wb_from == prod1) rdy1 <= 1'b1;
               if (wb_en && !rdy2 && wb_from == prod2) rdy2 <= 1'b1;
            end
            PH_EXEC: begin
               if (cnt == '0) ph <= PH_HOLD;
               else           cnt <= cnt - 1'b1;
            end
            default: if (grant) ph <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
   import sb_pkg::*;
#(
   parameter int NREG       = 8,
   parameter int TAG_W      = 8,
   parameter int LAT_SIMPLE = 1,
   parameter int LAT_FADD   = 2,
   parameter int LAT_FMUL   = 4,
   parameter int LAT_FDIV   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [CLASS_W-1:0]      in_class,
   input  logic [$clog2(NREG)-1:0] in_dst,
   input  logic [$clog2(NREG)-1:0] in_src1,
   input  logic [$clog2(NREG)-1:0] in_src2,
   input  logic [TAG_W-1:0]        in_tag,
   output logic                    in_ready,
   output logic [UNIT_W-1:0]       iss_unit,
   output logic [NUM_UNIT-1:0]     fu_start,
   output logic [NUM_UNIT-1:0]     fu_grant,
   output logic                    wb_valid,
   output logic [UNIT_W-1:0]       wb_unit,
   output logic [$clog2(NREG)-1:0] wb_reg,
   output logic [TAG_W-1:0]        wb_tag,
   output logic [TAG_W-1:0]        wb_op1,
   output logic [TAG_W-1:0]        wb_op2
);
   localparam int RW = $clog2(NREG);
   localparam int NU = NUM_UNIT;

   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (LAT_SIMPLE < 1 || LAT_FADD < 1 || LAT_FMUL < 1 || LAT_FDIV < 1) begin : g_bad_lat
      $error("every unit latency must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be positive");
   end

   // register status
   logic [NREG-1:0]   pend_v;
   logic [UNIT_W-1:0] pend_u   [NREG];
   logic [TAG_W-1:0]  arch_tag [NREG];

   // unit status
   logic [NU-1:0]    u_busy, u_wait, u_hold, u_rdy1, u_rdy2, u_req, u_block;
   logic [RW-1:0]    u_dst [NU], u_src1 [NU], u_src2 [NU];
   logic [TAG_W-1:0] u_tag [NU], u_res1 [NU], u_res2 [NU];

   logic fire;
   logic src1_ok, src2_ok;

   assign fire = in_valid && in_ready;

   sb_issue #(.NREG(NREG)) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_class (in_class),
      .in_dst   (in_dst),
      .pend_v   (pend_v),
      .unit_busy(u_busy),
      .in_ready (in_ready),
      .pick     (iss_unit)
   );

   sb_regstat #(.NREG(NREG), .TAG_W(TAG_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (fire),
      .set_reg (in_dst),
      .set_unit(iss_unit),
      .clr_en  (wb_valid),
      .clr_reg (wb_reg),
      .clr_tag (wb_tag),
      .pend_v  (pend_v),
      .pend_u  (pend_u),
      .arch_tag(arch_tag)
   );

   // a source is ready at issue when nobody owes it, or its producer writes now
   assign src1_ok = !pend_v[in_src1] || (wb_valid && wb_unit == pend_u[in_src1]);
   assign src2_ok = !pend_v[in_src2] || (wb_valid && wb_unit == pend_u[in_src2]);

   for (genvar g = 0; g < NU; g++) begin : g_unit
      localparam int CLS = unit_class(g);
      localparam int LAT = (CLS == int'(CL_FMUL)) ? LAT_FMUL :
                           (CLS == int'(CL_FDIV)) ? LAT_FDIV :
                           (CLS == int'(CL_FADD)) ? LAT_FADD : LAT_SIMPLE;
      logic [TAG_W-1:0] opnd1, opnd2;
      assign opnd1 = arch_tag[u_src1[g]];
      assign opnd2 = arch_tag[u_src2[g]];

      sb_unit #(.RW(RW), .TAG_W(TAG_W), .LAT(LAT)) u_fu (
         .clk      (clk),
         .rst_n    (rst_n),
         .iss_en   (fire && iss_unit == UNIT_W'(g)),
         .iss_dst  (in_dst),
         .iss_src1 (in_src1),
         .iss_src2 (in_src2),
         .iss_tag  (in_tag),
         .iss_rdy1 (src1_ok),
         .iss_rdy2 (src2_ok),
         .iss_prod1(pend_u[in_src1]),
         .iss_prod2(pend_u[in_src2]),
         .wb_en    (wb_valid),
         .wb_from  (wb_unit),
         .opnd1    (opnd1),
         .opnd2    (opnd2),
         .grant    (fu_grant[g]),
         .busy     (u_busy[g]),
         .waiting  (u_wait[g]),
         .start    (fu_start[g]),
         .hold     (u_hold[g]),
         .dst      (u_dst[g]),
         .src1     (u_src1[g]),
         .src2     (u_src2[g]),
         .rdy1     (u_rdy1[g]),
         .rdy2     (u_rdy2[g]),
         .tag      (u_tag[g]),
         .res1     (u_res1[g]),
         .res2     (u_res2[g])
      );

      // a held result waits while another unit still has to read its destination
      always_comb begin
         u_block[g] = 1'b0;
         for (int w = 0; w < NU; w++) begin
            if (w != g && u_wait[w] &&
                ((u_src1[w] == u_dst[g] && u_rdy1[w]) ||
                 (u_src2[w] == u_dst[g] && u_rdy2[w])))
               u_block[g] = 1'b1;
         end
      end
      assign u_req[g] = u_hold[g] && !u_block[g];
   end

   // single write port, lowest unit number first
   always_comb begin
      wb_unit = '0;
      for (int u = NU-1; u >= 0; u--)
         if (u_req[u]) wb_unit = UNIT_W'(u);
   end

   assign wb_valid = |u_req;
   assign fu_grant = wb_valid ? (NU'(1) << wb_unit) : '0;
   assign wb_reg   = u_dst[wb_unit];
   assign wb_tag   = u_tag[wb_unit];
   assign wb_op1   = u_res1[wb_unit];
   assign wb_op2   = u_res2[wb_unit];
endmodule

// File: rtl/sb_chk.sv
module sb_chk
   import sb_pkg::*;
#(
   parameter int NREG = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [CLASS_W-1:0]      in_class,
   input logic [$clog2(NREG)-1:0] in_dst,
   input logic                    in_ready,
   input logic [UNIT_W-1:0]       iss_unit,
   input logic [NUM_UNIT-1:0]     fu_start,
   input logic [NUM_UNIT-1:0]     fu_grant,
   input logic                    wb_valid
);
   localparam int RW = $clog2(NREG);

   logic [NUM_UNIT-1:0] busy_c, read_c, young_c;
   logic [RW-1:0]       dst_c [NUM_UNIT];
   logic [1:0]          age_c [NUM_UNIT];
   logic                fire, dst_clash, cls_ok;

   assign fire = in_valid && in_ready;

   always_comb begin
      dst_clash = 1'b0;
      cls_ok    = 1'b0;
      for (int u = 0; u < NUM_UNIT; u++) begin
         if (busy_c[u] && dst_c[u] == in_dst) dst_clash = 1'b1;
         if (iss_unit == UNIT_W'(u) && in_class == CLASS_W'(unit_class(u))) cls_ok = 1'b1;
         young_c[u] = (age_c[u] < 2'd2);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_c <= '0;
         read_c <= '0;
         for (int u = 0; u < NUM_UNIT; u++) begin
            dst_c[u] <= '0;
            age_c[u] <= '0;
         end
      end else begin
         for (int u = 0; u < NUM_UNIT; u++) begin
            if (age_c[u] != 2'd3) age_c[u] <= age_c[u] + 2'd1;
            if (fu_start[u]) read_c[u] <= 1'b1;
            if (fu_grant[u]) busy_c[u] <= 1'b0;
            if (fire && iss_unit == UNIT_W'(u)) begin
               busy_c[u] <= 1'b1;
               read_c[u] <= 1'b0;
               dst_c[u]  <= in_dst;
               age_c[u]  <= '0;
            end
         end
      end
   end

   p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fu_grant) && (wb_valid == (|fu_grant)));

   p_class_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> cls_ok);

   p_idle_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !busy_c[iss_unit]);

   p_dst_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !dst_clash);

   p_read_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_grant & ~read_c) == '0);

   p_min_cycles_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_grant & busy_c & young_c) == '0);

   p_no_idle_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fu_grant & ~busy_c) == '0);
endmodule

bind hazard_scoreboard sb_chk #(.NREG(NREG)) u_sb_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_valid(in_valid),
   .in_class(in_class),
   .in_dst  (in_dst),
   .in_ready(in_ready),
   .iss_unit(iss_unit),
   .fu_start(fu_start),
   .fu_grant(fu_grant),
   .wb_valid(wb_valid)
);

// File: tb/tb_hazard_scoreboard.sv
module tb_hazard_scoreboard;
   import sb_pkg::*;

   localparam int NREG = 8;
   localparam int RW   = 3;
   localparam int TW   = 8;
   localparam int LAT_DIV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    in_class = '0;
   logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic [TW-1:0] in_tag = '0;
   logic          in_ready;
   logic [3:0]    iss_unit;
   logic [9:0]    fu_start, fu_grant;
   logic          wb_valid;
   logic [3:0]    wb_unit;
   logic [RW-1:0] wb_reg;
   logic [TW-1:0] wb_tag, wb_op1, wb_op2;

   always #10 clk = ~clk;

   hazard_scoreboard #(.NREG(NREG), .TAG_W(TW), .LAT_FDIV(LAT_DIV)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_tag(in_tag),
      .in_ready(in_ready), .iss_unit(iss_unit), .fu_start(fu_start),
      .fu_grant(fu_grant), .wb_valid(wb_valid), .wb_unit(wb_unit),
      .wb_reg(wb_reg), .wb_tag(wb_tag), .wb_op1(wb_op1), .wb_op2(wb_op2)
   );

   typedef struct { logic [TW-1:0] tag, op1, op2; } exp_t;
   exp_t          exp_q [NREG][$];
   logic [TW-1:0] model [NREG];
   logic [TW-1:0] seen  [NREG];
   logic [TW-1:0] wb_log [$];
   int n_chk = 0, n_err = 0, next_tag = 1;
   int last_unit;
   logic [TW-1:0] last_tag;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic present(input fu_class_e c, input int d, input int s1, input int s2);
      in_class = c;
      in_dst   = RW'(d);
      in_src1  = RW'(s1);
      in_src2  = RW'(s2);
      in_tag   = TW'(next_tag);
      in_valid = 1'b1;
      #1;
   endtask

   // completes the handshake started by present; pushes the in-order expectation
   task automatic accept();
      exp_t e;
      while (!in_ready) @(negedge clk);
      last_unit = int'(iss_unit);
      last_tag  = in_tag;
      e.tag = in_tag;
      e.op1 = model[in_src1];
      e.op2 = model[in_src2];
      exp_q[in_dst].push_back(e);
      model[in_dst] = in_tag;
      next_tag++;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic issue(input fu_class_e c, input int d, input int s1, input int s2);
      present(c, d, s1, s2);
      accept();
   endtask

   task automatic drain();
      int guard = 0;
      bit busy_q = 1;
      while (busy_q && guard < 3000) begin
         busy_q = 0;
         for (int r = 0; r < NREG; r++) if (exp_q[r].size() != 0) busy_q = 1;
         if (busy_q) begin @(negedge clk); guard++; end
      end
      check(!busy_q, "R10", "drain timeout", guard, 0);
      repeat (2) @(negedge clk);
   endtask

   function automatic int pos_of(input logic [TW-1:0] t);
      for (int i = 0; i < wb_log.size(); i++) if (wb_log[i] == t) return i;
      return -1;
   endfunction

   // monitor: pops the expectation for the written register
   always @(negedge clk) begin
      if (rst_n && wb_valid) begin
         wb_log.push_back(wb_tag);
         seen[wb_reg] = wb_tag;
         if (exp_q[wb_reg].size() == 0) begin
            check(0, "R10", "unexpected write", int'(wb_tag), 0);
         end else begin
            exp_t e;
            e = exp_q[wb_reg].pop_front();
            check(wb_tag == e.tag, "R10", "write order tag", int'(wb_tag), int'(e.tag));
            check(wb_op1 == e.op1 && wb_op2 == e.op2, "R6 R7", "operand tags",
                  int'({wb_op1, wb_op2}), int'({e.op1, e.op2}));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int k;
      logic [TW-1:0] ta, tb2, tc;
      for (int r = 0; r < NREG; r++) begin model[r] = '0; seen[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      present(CL_FDIV, 0, 1, 2);
      check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      check(fu_start == '0, "R1", "fu_start after reset", fu_start, 0);
      check(fu_grant == '0 && !wb_valid, "R1", "no write after reset", fu_grant, 0);
      in_valid = 1'b0;

      // R2 class to unit map
      issue(CL_FDIV, 1, 2, 3);
      check(last_unit == 7, "R2", "divide unit", last_unit, 7);
      issue(CL_BRANCH, 2, 1, 0);
      check(last_unit == 0, "R2", "branch unit", last_unit, 0);
      issue(CL_INCR, 3, 3, 3);
      check(last_unit == 8, "R2", "incrementer unit", last_unit, 8);
      drain();

      // R5 busy copy makes the twin take it; R3 stall when both busy
      issue(CL_FMUL, 1, 2, 3);
      check(last_unit == 5, "R5", "first multiply copy", last_unit, 5);
      issue(CL_FMUL, 2, 3, 4);
      check(last_unit == 6, "R5", "second multiply copy", last_unit, 6);
      present(CL_FMUL, 3, 4, 5);
      check(in_ready == 1'b0, "R3", "stall with both copies busy", in_ready, 0);
      accept();
      check(last_unit == 5, "R3", "freed copy taken", last_unit, 5);
      drain();
      issue(CL_FMUL, 4, 0, 0);
      check(last_unit == 6, "R5", "alternate when both idle", last_unit, 6);
      drain();

      // R4 destination reservation
      issue(CL_FDIV, 4, 1, 2);
      present(CL_IADD, 4, 5, 6);
      check(in_ready == 1'b0, "R4", "stall on reserved destination", in_ready, 0);
      present(CL_IADD, 5, 6, 7);
      check(in_ready == 1'b1, "R4", "other destination accepted", in_ready, 1);
      accept();
      issue(CL_IADD, 4, 5, 6);
      drain();

      // R8 latency
      issue(CL_LOGIC, 6, 1, 2);
      k = 0;
      while (!wb_valid && k < 50) begin @(negedge clk); k++; end
      check(k == 2, "R8", "simple unit write cycle", k, 2);
      drain();
      issue(CL_FDIV, 6, 1, 2);
      k = 0;
      while (!wb_valid && k < 50) begin @(negedge clk); k++; end
      check(k == LAT_DIV + 1, "R8", "divide unit write cycle", k, LAT_DIV + 1);
      drain();

      // R11 unit free only after its write-back cycle
      issue(CL_FDIV, 1, 2, 3);
      present(CL_FDIV, 2, 3, 4);
      k = 0;
      while (!wb_valid && k < 50) begin @(negedge clk); k++; end
      check(in_ready == 1'b0, "R11", "busy during write cycle", in_ready, 0);
      @(negedge clk);
      check(in_ready == 1'b1, "R11", "free after write cycle", in_ready, 1);
      accept();
      drain();

      // R6 / R7 dependent chain
      issue(CL_FDIV, 1, 2, 3);
      ta = last_tag;
      issue(CL_FMUL, 4, 1, 2);
      tb2 = last_tag;
      issue(CL_LOGIC, 2, 3, 3);
      tc = last_tag;
      drain();
      check(pos_of(tb2) > pos_of(ta), "R6", "reader written after producer",
            pos_of(tb2), pos_of(ta) + 1);
      check(pos_of(tc) > pos_of(ta), "R7", "overwrite held past older read",
            pos_of(tc), pos_of(ta) + 1);

      // R9 two results ready in the same cycle
      issue(CL_FMUL, 5, 0, 0);
      ta = last_tag;
      repeat (2) @(negedge clk);
      issue(CL_LOGIC, 6, 0, 0);
      tb2 = last_tag;
      drain();
      check(pos_of(tb2) < pos_of(ta), "R9", "lower unit writes first",
            pos_of(tb2), pos_of(ta) - 1);

      // R10 mixed stream against in-order model
      for (int i = 0; i < 150; i++)
         issue(fu_class_e'($urandom_range(0, 7)), $urandom_range(0, NREG-1),
               $urandom_range(0, NREG-1), $urandom_range(0, NREG-1));
      drain();
      for (int r = 0; r < NREG; r++)
         check(seen[r] == model[r], "R10", "final register tag", seen[r], model[r]);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule